// File: doc/BRIEF.md
# User-Mode Dummy-Byte Snooper

This block sits on the path of bytes that software writes, one access at a time, into a serial-flash controller's user-mode data port. After the chip select is driven active, it takes the first byte written as a flash opcode. It looks the opcode up to learn how many dummy units the command needs. If the command needs any, the block counts the address bytes that follow. Once the opcode and the full address have gone out, it swallows the next software write, which would have been the software's own dummy write. In its place it drives count × 8 dummy bytes onto the serial bus, one per clock. Each dummy byte carries a programmable fill value.

Every write the block does not swallow is passed through unchanged on a forward port, one cycle after it is accepted. While dummy bytes are being emitted, the host port is stalled. The block is controlled by a four-state machine:
- OFF: passive, every write is forwarded.
- OPCODE: armed, the next write is decoded as an opcode.
- ADDRESS: counting the opcode and address bytes.
- INSERT: emitting dummy bytes.

The transitions are:
- arm: any state to OPCODE, when the chip-select stop flag is written as 0.
- disarm: any state to OFF, when the stop flag is written as 1.
- no-dummy: OPCODE to OFF, on an opcode that needs no dummies or is unknown.
- need-dummy: OPCODE to ADDRESS.
- trigger: ADDRESS to INSERT.
- drained: INSERT to OFF, after the last dummy byte.

Top module: `dsnoop_top`

## Requirements
- R1: After reset the block is OFF. `wr_ready` is 1, no dummy byte or swallow is produced, and every accepted write is forwarded.
- R2: A pulse on `cs_upd` with `cs_stop`=0 arms the snooper (OPCODE) and clears the byte index. A pulse with `cs_stop`=1 turns it OFF, so later writes never cause insertion.
- R3: In OPCODE, an accepted write whose low byte (`wr_data[7:0]`) is 0x03, 0x13, 0x02, 0x12, 0xA2, 0x32 or 0x34 is forwarded and turns snooping OFF, with no insertion.
- R4: Opcodes 0x0B, 0x3B, 0x6B, 0x3C and 0x6C need one dummy unit, which is 8 dummy bytes.
- R5: Opcodes 0xBB, 0xBC and 0x0C need two units, which is 16 dummy bytes.
- R6: Opcodes 0xEB and 0xEC need four units, which is 32 dummy bytes.
- R7: Any other opcode is forwarded and turns snooping OFF, with no insertion.
- R8: The opcode write sets the byte index to its size (`wr_size`, 1 to 4 bytes). Each later forwarded write in ADDRESS adds its size. The first write accepted in ADDRESS while the index is at least 4 (`addr4`=0) or 5 (`addr4`=1) is swallowed. For that write `swallow` pulses one cycle after acceptance instead of `fwd_valid`.
- R9: Dummy bytes appear on `dum_valid`/`dum_byte` on consecutive cycles, starting in the cycle `swallow` is high. Each carries the `dummy_byte` value sampled when the trigger write was accepted. After the last one the block is OFF.
- R10: `wr_ready` is 0 in exactly the cycles in which `dum_valid` is 1. A write held during that time is accepted only after the last dummy byte.
- R11: A forwarded write shows `fwd_valid` for one cycle, one cycle after acceptance, with its data and size unchanged.
- R12: A `cs_upd` pulse takes priority over snooping. A write accepted in the same cycle is forwarded without being decoded or counted. A pulse during INSERT stops the remaining dummy bytes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_upd | input | 1 | Pulse: software wrote the chip-select stop flag |
| cs_stop | input | 1 | New value of the stop flag (1 = deselect) |
| addr4 | input | 1 | 1 = 4-byte addresses, 0 = 3-byte addresses |
| dummy_byte | input | 8 | Fill value for inserted dummy bytes |
| wr_valid | input | 1 | Software write request on the data port |
| wr_data | input | 32 | Write data, first byte in bits 7:0 |
| wr_size | input | 3 | Write size in bytes (1 to 4) |
| wr_ready | output | 1 | Write accepted when high together with `wr_valid` |
| fwd_valid | output | 1 | Forwarded write valid |
| fwd_data | output | 32 | Forwarded write data |
| fwd_size | output | 3 | Forwarded write size |
| swallow | output | 1 | Pulse: the accepted write was suppressed |
| dum_valid | output | 1 | Inserted dummy byte valid |
| dum_byte | output | 8 | Inserted dummy byte value |

## Verification
A wrong state or byte index shows at the ports as a swallow pulse on the wrong write. The same fault shows as a dummy burst of the wrong length, or as a burst that never comes. Both appear one cycle after the write that should have triggered. A stale pending count or fill value shows on `dum_byte` and `dum_valid` within the burst itself. Any disagreement between the state machine and the burst counter shows as `wr_ready` out of step with `dum_valid` in the same cycle. The bench therefore compares every output on every clock against a behavioural model.

// File: rtl/dsnoop_pkg.sv
package dsnoop_pkg;
    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ADDR   = 2'd2,
        ST_INSERT = 2'd3
    } snoop_st_e;

    localparam int ADDR_SHORT = 3;
    localparam int ADDR_LONG  = 4;
endpackage

// File: rtl/dsnoop_opdec.sv
module dsnoop_opdec #(
    parameter int UNITW = 3
) (
    input  logic [7:0]       opcode,
    output logic [UNITW-1:0] units
);
    always_comb begin
        case (opcode)
            8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C: units = UNITW'(1);
            8'hBB, 8'hBC, 8'h0C:               units = UNITW'(2);
            8'hEB, 8'hEC:                      units = UNITW'(4);
            default:                           units = '0;
        endcase
    end
endmodule

// File: rtl/dsnoop_burst.sv
module dsnoop_burst #(
    parameter int CNTW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            abort,
    input  logic            start,
    input  logic [CNTW-1:0] load,
    input  logic [7:0]      fill,
    output logic            valid,
    output logic [7:0]      data,
    output logic            last
);
    logic [CNTW-1:0] cnt;
    logic [7:0]      fill_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            fill_q <= '0;
        end else if (abort) begin
            cnt <= '0;
        end else if (start) begin
            cnt    <= load;
            fill_q <= fill;
        end else if (cnt != '0) begin
            cnt <= cnt - CNTW'(1);
        end
    end

    assign valid = (cnt != '0);
    assign last  = (cnt == CNTW'(1));
    assign data  = fill_q;

    assert_burst_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !last && !abort |=> valid && $stable(data));
endmodule

// File: rtl/dsnoop_top.sv
module dsnoop_top #(
    parameter int DATA_BYTES = 4,
    parameter int UNIT_BYTES = 8,
    parameter int MAX_UNITS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_upd,
    input  logic                      cs_stop,
    input  logic                      addr4,
    input  logic [7:0]                dummy_byte,
    input  logic                      wr_valid,
    input  logic [8*DATA_BYTES-1:0]   wr_data,
    input  logic [$clog2(DATA_BYTES+1)-1:0] wr_size,
    output logic                      wr_ready,
    output logic                      fwd_valid,
    output logic [8*DATA_BYTES-1:0]   fwd_data,
    output logic [$clog2(DATA_BYTES+1)-1:0] fwd_size,
    output logic                      swallow,
    output logic                      dum_valid,
    output logic [7:0]                dum_byte
);
    import dsnoop_pkg::*;

    localparam int DW    = 8 * DATA_BYTES;
    localparam int SZW   = $clog2(DATA_BYTES + 1);
    localparam int IDXW  = $clog2(2 * DATA_BYTES + 6);
    localparam int CNTW  = $clog2(MAX_UNITS * UNIT_BYTES + 1);
    localparam int UNITW = $clog2(MAX_UNITS + 1);

    snoop_st_e       state, state_n;
    logic [IDXW-1:0] idx, idx_n, idx_lim;
    logic [CNTW-1:0] pend, pend_n;
    logic [UNITW-1:0] units;
    logic            accept, fire, fwd_n, sw_n, dum_last;

    assign accept  = wr_valid && wr_ready;
    assign wr_ready = (state != ST_INSERT);
    assign idx_lim = addr4 ? IDXW'(ADDR_LONG + 1) : IDXW'(ADDR_SHORT + 1);

    dsnoop_opdec #(.UNITW(UNITW)) u_opdec (
        .opcode (wr_data[7:0]),
        .units  (units)
    );

    dsnoop_burst #(.CNTW(CNTW)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .abort (cs_upd),
        .start (fire),
        .load  (pend),
        .fill  (dummy_byte),
        .valid (dum_valid),
        .data  (dum_byte),
        .last  (dum_last)
    );

    // next-state and next-output decision
    always_comb begin
        state_n = state;
        idx_n   = idx;
        pend_n  = pend;
        fire    = 1'b0;
        fwd_n   = 1'b0;
        sw_n    = 1'b0;
        if (cs_upd) begin
            state_n = cs_stop ? ST_OFF : ST_OPCODE;
            idx_n   = '0;
            fwd_n   = accept;
        end else begin
            unique case (state)
                ST_OFF: fwd_n = accept;
                ST_OPCODE: begin
                    if (accept) begin
                        fwd_n = 1'b1;
                        if (units == '0) begin
                            state_n = ST_OFF;
                        end else begin
                            pend_n  = CNTW'(units) * CNTW'(UNIT_BYTES);
                            idx_n   = IDXW'(wr_size);
                            state_n = ST_ADDR;
                        end
                    end
                end
                ST_ADDR: begin
                    if (accept) begin
                        if (idx >= idx_lim) begin
                            sw_n    = 1'b1;
                            fire    = 1'b1;
                            state_n = ST_INSERT;
                        end else begin
                            fwd_n = 1'b1;
                            idx_n = idx + IDXW'(wr_size);
                        end
                    end
                end
                ST_INSERT: if (dum_last) state_n = ST_OFF;
                default: state_n = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            idx   <= '0;
            pend  <= '0;
        end else begin
            state <= state_n;
            idx   <= idx_n;
            pend  <= pend_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
            fwd_size  <= '0;
            swallow   <= 1'b0;
        end else begin
            fwd_valid <= fwd_n;
            swallow   <= sw_n;
            if (accept) begin
                fwd_data <= wr_data;
                fwd_size <= wr_size;
            end
        end
    end

    assert_busy_matches_burst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INSERT) == dum_valid);
    assert_swallow_starts_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        swallow |-> dum_valid);
    assert_swallow_excl_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(swallow && fwd_valid));
    assert_stall_no_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ready |-> !fwd_valid);
endmodule

// File: tb/tb_dsnoop_top.sv
module tb_dsnoop_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_upd = 1'b0, cs_stop = 1'b1, addr4 = 1'b0;
    logic [7:0]  dummy_byte = 8'h00;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic [2:0]  wr_size = 3'd1;
    logic        wr_ready, fwd_valid, swallow, dum_valid;
    logic [31:0] fwd_data;
    logic [2:0]  fwd_size;
    logic [7:0]  dum_byte;

    int n_chk = 0, n_fail = 0, cnt_dum = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    dsnoop_top dut (
        .clk(clk), .rst_n(rst_n), .cs_upd(cs_upd), .cs_stop(cs_stop),
        .addr4(addr4), .dummy_byte(dummy_byte), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_size(wr_size), .wr_ready(wr_ready),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_size(fwd_size),
        .swallow(swallow), .dum_valid(dum_valid), .dum_byte(dum_byte)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int units_of(input logic [7:0] op);
        if (op inside {8'h0B, 8'h3B, 8'h6B, 8'h3C, 8'h6C}) return 1;
        if (op inside {8'hBB, 8'hBC, 8'h0C}) return 2;
        if (op inside {8'hEB, 8'hEC}) return 4;
        return 0;
    endfunction

    // behavioural reference: mode 0 off, 1 expect opcode, 2 counting address
    int m_mode = 0, m_idx = 0, m_pend = 0, m_left = 0;
    logic [7:0]  m_fill = 0;
    bit e_ready = 1, e_dv = 0, e_fwd = 0, e_sw = 0;
    logic [7:0]  e_db = 0;
    logic [31:0] e_fd = 0;
    logic [2:0]  e_fs = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_idx = 0; m_pend = 0; m_left = 0; m_fill = 0;
            e_fwd = 0; e_sw = 0;
        end else begin
            bit acc;
            acc = wr_valid && (m_left == 0);
            e_fwd = 0; e_sw = 0;
            if (m_left > 0) m_left--;
            if (acc) begin e_fd = wr_data; e_fs = wr_size; end
            if (cs_upd) begin
                m_left = 0; m_idx = 0;
                m_mode = cs_stop ? 0 : 1;
                e_fwd = acc;
            end else if (acc) begin
                if (m_mode == 0) e_fwd = 1;
                else if (m_mode == 1) begin
                    e_fwd = 1;
                    if (units_of(wr_data[7:0]) == 0) m_mode = 0;
                    else begin
                        m_pend = units_of(wr_data[7:0]) * 8;
                        m_idx = int'(wr_size); m_mode = 2;
                    end
                end else begin
                    if (m_idx >= (addr4 ? 5 : 4)) begin
                        e_sw = 1; m_left = m_pend; m_fill = dummy_byte; m_mode = 0;
                    end else begin
                        e_fwd = 1; m_idx += int'(wr_size);
                    end
                end
            end
        end
        e_ready = (m_left == 0);
        e_dv = (m_left != 0);
        e_db = m_fill;
    end

    // every-clock comparison away from the edge
    always @(negedge clk) begin
        if (dum_valid) cnt_dum++;
        chk(wr_ready == e_ready, "R10 wr_ready", wr_ready, e_ready);
        chk(dum_valid == e_dv, "R9 dum_valid", dum_valid, e_dv);
        if (e_dv) chk(dum_byte == e_db, "R9 dum_byte", dum_byte, e_db);
        chk(fwd_valid == e_fwd, "R11 fwd_valid", fwd_valid, e_fwd);
        if (e_fwd) begin
            chk(fwd_data == e_fd, "R11 fwd_data", fwd_data, e_fd);
            chk(fwd_size == e_fs, "R11 fwd_size", fwd_size, e_fs);
        end
        chk(swallow == e_sw, "R8 swallow", swallow, e_sw);
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [31:0] d, input int s);
        while (!wr_ready) tick();
        wr_valid = 1; wr_data = d; wr_size = 3'(s);
        tick();
        wr_valid = 0;
    endtask

    task automatic cs(input bit stop);
        cs_upd = 1; cs_stop = stop;
        tick();
        cs_upd = 0;
    endtask

    task automatic cs_wr(input bit stop, input logic [31:0] d, input int s);
        while (!wr_ready) tick();
        cs_upd = 1; cs_stop = stop; wr_valid = 1; wr_data = d; wr_size = 3'(s);
        tick();
        cs_upd = 0; wr_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) tick();
    endtask

    // opcode, one 3-byte address write, then the dummy write; count bytes
    task automatic simple_cmd(input logic [7:0] op, input int exp_n, input string req);
        cnt_dum = 0;
        cs(0);
        wr({24'h0, op}, 1);
        wr(32'h00_12_34_56, 3);
        wr(32'hFF, 1);
        idle(40);
        chk(cnt_dum == exp_n, req, cnt_dum, exp_n);
        cs(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        #1;
        // R1: reset state, writes pass through
        chk(wr_ready == 1 && dum_valid == 0 && swallow == 0 && fwd_valid == 0,
            "R1 reset outputs", {wr_ready, dum_valid, swallow, fwd_valid}, 4'b1000);
        cnt_dum = 0;
        wr(32'h0B, 1); wr(32'h123456, 3); wr(32'h00, 1); idle(12);
        chk(cnt_dum == 0, "R1 off no insertion", cnt_dum, 0);

        // R4 with fill captured at trigger (R9)
        dummy_byte = 8'h5A;
        cnt_dum = 0;
        cs(0); wr(32'h0B, 1); wr(32'h123456, 3); wr(32'hAA, 1);
        dummy_byte = 8'h11;
        idle(12);
        chk(cnt_dum == 8, "R4 one unit", cnt_dum, 8);
        cnt_dum = 0;
        wr(32'hAA, 1); idle(4);
        chk(cnt_dum == 0, "R9 off after insertion", cnt_dum, 0);
        simple_cmd(8'h6C, 8, "R4 opcode 6C");

        // R5: 4-byte address in one write, and byte-by-byte
        addr4 = 1; cnt_dum = 0;
        cs(0); wr(32'hBC, 1); wr(32'h01020304, 4); wr(32'h0, 1); idle(24);
        chk(cnt_dum == 16, "R5 four-byte address", cnt_dum, 16);
        addr4 = 0; cnt_dum = 0;
        cs(0); wr(32'hBB, 1); wr(1, 1); wr(2, 1); wr(3, 1); wr(32'h0, 1); idle(24);
        chk(cnt_dum == 16, "R8 byte-wise index", cnt_dum, 16);
        simple_cmd(8'h0C, 16, "R5 opcode 0C");

        // R6 and R10 stall: a write held until the burst ends
        cnt_dum = 0;
        cs(0); wr(32'h563412EB, 4); wr(32'h0, 1);
        wr(32'h77, 1);
        chk(cnt_dum == 32, "R10 write held during burst", cnt_dum, 32);
        idle(3);
        chk(cnt_dum == 32, "R6 four units", cnt_dum, 32);

        // R3 and R7
        simple_cmd(8'h03, 0, "R3 opcode 03");
        simple_cmd(8'h34, 0, "R3 opcode 34");
        simple_cmd(8'h9F, 0, "R7 unknown opcode");

        // R2: disarm before trigger
        cnt_dum = 0;
        cs(0); wr(32'h3B, 1); wr(32'h123456, 3); cs(1); wr(32'h0, 1); idle(12);
        chk(cnt_dum == 0, "R2 disarm", cnt_dum, 0);

        // R12: write with cs pulse is not decoded; abort mid-burst
        cnt_dum = 0;
        cs_wr(0, 32'h03, 1); wr(32'h0B, 1); wr(32'h123456, 3); wr(32'h0, 1); idle(12);
        chk(cnt_dum == 8, "R12 same-cycle write not decoded", cnt_dum, 8);
        cnt_dum = 0;
        cs(0); wr(32'hEB, 1); wr(32'h123456, 3); wr(32'h0, 1); idle(3); cs(1); idle(40);
        chk(cnt_dum > 0 && cnt_dum < 32, "R12 abort burst", cnt_dum, 4);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog act=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule